// File: doc/BRIEF.md
# 64-bit Memory-Mapped Machine Timer

This block is a processor-local timer. It holds a 64-bit up-counter and a 64-bit compare value, and it drives a registered timer interrupt while the counter is above the compare value. Software reaches both through a small word-wide register bus. Each 64-bit value is split into a low and a high 32-bit word. A control word can pause the count. It can also make the counter fall back to zero once it passes the compare value, and it picks what makes the counter step.

The counter steps from one of two sources. One is an always-on tick, given as a single-cycle enable in the bus clock domain. The other is an external toggle line, which is passed through a synchroniser; each rising edge of the synchronised line is one step. With the default control word the toggle line is the source, so the counter runs after reset without any enable from software. Bus accesses are single-cycle. Read data comes back on `bus_rdata` one clock after the access.

Top module: `tick_timer64`

## Requirements
- R1: After reset the counter reads 0, both compare words read 0xFFFFFFFF, the control word reads 0 and `timer_irq` is 0.
- R2: Word map: counter low word at offset 0x000, counter high word at 0x004, compare low word at 0x008, compare high word at 0x00C, control word at 0xFF8. Read data appears on `bus_rdata` in the cycle after the read access.
- R3: `timer_irq` is a register. It is 1 in the cycle after the counter is strictly greater (unsigned) than the compare value, and 0 when the counter is equal to it or below it. Rewriting the compare value above the counter drops the interrupt one cycle later.
- R4: When control bit 0 (stop) is 1, the counter keeps its value whatever tick or toggle activity there is.
- R5: When control bit 1 (clear-on-compare) is 1 and the counter is above the compare value, the counter becomes 0 on the next edge, so `timer_irq` is a one-cycle pulse. When the bit is 0, the counter keeps counting and `timer_irq` stays at 1.
- R6: When control bit 2 (source select) is 1, the counter steps by one on every clock edge at which `aon_tick` is 1.
- R7: When control bit 2 is 0, `toggle_in` passes through a two-flop synchroniser. The counter steps by one for each rising edge of the synchronised signal. Holding the line high does not add further steps.
- R8: Reads of offsets 0x000 to 0xFFF that hold no register return 0, as do misaligned reads (address bits 1:0 not zero). Writes to such offsets, and misaligned writes, change no register. Control bits 31:3 read as 0.
- R9: A bus write to a counter word wins over a step in the same cycle, and it replaces only the addressed 32-bit word. A step carries from the low word into the high word.
- R10: The counter counts after reset with no software write. Under the reset control word, toggle edges advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read |
| aon_tick | input | 1 | Always-on step enable, one cycle per step |
| toggle_in | input | 1 | Asynchronous external toggle line |
| timer_irq | output | 1 | Registered timer interrupt level |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, 32-bit words (so the counter is 64 bits wide) and two synchroniser stages. Because the counter words are 32 bits wide, the bench can write a low word of 0xFFFFFFFF and reach the carry into the high word in one step. It keeps the tick at 0 and the toggle line quiet while it reads, so each counter value it reads back is exact. It then sets up the equal case and the one-above case for the compare by direct writes and single ticks.

// File: rtl/tick_timer64_pkg.sv
package tick_timer64_pkg;
  localparam int OFS_CNT_LO = 'h000;
  localparam int OFS_CNT_HI = 'h004;
  localparam int OFS_CMP_LO = 'h008;
  localparam int OFS_CMP_HI = 'h00C;
  localparam int OFS_CTRL   = 'hFF8;

  localparam int CTRL_STOP_BIT  = 0;
  localparam int CTRL_CLREN_BIT = 1;
  localparam int CTRL_SRC_BIT   = 2;
  localparam int CTRL_W         = 3;

  typedef struct packed {
    logic src_aon;
    logic clr_en;
    logic stop;
  } ctrl_t;
endpackage

// File: rtl/tmr_step_src.sv
module tmr_step_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic toggle_in,
  input  logic aon_tick,
  input  logic sel_aon,
  output logic step
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= toggle_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign rise = sync_q[LAST] & ~prev_q;

  always_comb begin
    if (sel_aon) step = aon_tick;
    else         step = rise;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              stop,
  input  logic              clr_req,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[HALF-1:0]     = wdata[HALF-1:0];
      if (wr_hi) cnt_d[CNT_W-1:HALF] = wdata[HALF-1:0];
    end else if (clr_req) begin
      cnt_d = '0;
    end else if (step && !stop) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             clr_en,
  output logic             clr_req,
  output logic             irq
);
  logic above;
  logic irq_q;

  assign above   = cnt > cmp;
  assign clr_req = clr_en & above;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= above;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tick_timer64_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_cnt_lo,
  output logic              wr_cnt_hi,
  output logic [CNT_W-1:0]  cmp,
  output ctrl_t             ctrl
);
  localparam int HALF = CNT_W / 2;

  logic              aligned;
  logic              wr_en;
  logic              hit_cnt_lo, hit_cnt_hi, hit_cmp_lo, hit_cmp_hi, hit_ctrl;
  logic [CNT_W-1:0]  cmp_q;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign hit_cnt_lo = aligned && (bus_addr == ADDR_W'(OFS_CNT_LO));
  assign hit_cnt_hi = aligned && (bus_addr == ADDR_W'(OFS_CNT_HI));
  assign hit_cmp_lo = aligned && (bus_addr == ADDR_W'(OFS_CMP_LO));
  assign hit_cmp_hi = aligned && (bus_addr == ADDR_W'(OFS_CMP_HI));
  assign hit_ctrl   = aligned && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_en      = bus_sel && bus_wr;

  assign wr_cnt_lo = wr_en && hit_cnt_lo;
  assign wr_cnt_hi = wr_en && hit_cnt_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '1;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (hit_cmp_lo) cmp_q[HALF-1:0]     <= bus_wdata[HALF-1:0];
      if (hit_cmp_hi) cmp_q[CNT_W-1:HALF] <= bus_wdata[HALF-1:0];
      if (hit_ctrl) begin
        ctrl_q.stop    <= bus_wdata[CTRL_STOP_BIT];
        ctrl_q.clr_en  <= bus_wdata[CTRL_CLREN_BIT];
        ctrl_q.src_aon <= bus_wdata[CTRL_SRC_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cnt_lo)      rd_mux[HALF-1:0]   = cnt[HALF-1:0];
    else if (hit_cnt_hi) rd_mux[HALF-1:0]   = cnt[CNT_W-1:HALF];
    else if (hit_cmp_lo) rd_mux[HALF-1:0]   = cmp_q[HALF-1:0];
    else if (hit_cmp_hi) rd_mux[HALF-1:0]   = cmp_q[CNT_W-1:HALF];
    else if (hit_ctrl)   rd_mux[CTRL_W-1:0] = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= rd_mux;
    else                       rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign cmp       = cmp_q;
  assign ctrl      = ctrl_q;
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tick_timer64_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              aon_tick,
  input  logic              toggle_in,
  output logic              timer_irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  ctrl_t            ctrl;
  logic             wr_cnt_lo, wr_cnt_hi;
  logic             step;
  logic             clr_req;

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .bus_rdata(bus_rdata), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
    .cmp(cmp), .ctrl(ctrl)
  );

  tmr_step_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .toggle_in(toggle_in), .aon_tick(aon_tick),
    .sel_aon(ctrl.src_aon), .step(step)
  );

  tmr_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .stop(ctrl.stop), .clr_req(clr_req),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(cnt)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .cmp(cmp), .clr_en(ctrl.clr_en),
    .clr_req(clr_req), .irq(timer_irq)
  );
endmodule

// File: rtl/tick_timer64_chk.sv
module tick_timer64_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              stop,
  input logic              clr_en,
  input logic              step,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              timer_irq
);
  localparam int HALF = CNT_W / 2;

  logic any_wr;
  assign any_wr = wr_lo || wr_hi;

  AST_IRQ_STRICT_GT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (timer_irq == ($past(cnt) > $past(cmp)))); // R3

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stop && !any_wr && !(clr_en && cnt > cmp)) |=> (cnt == $past(cnt))); // R4

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (clr_en && cnt > cmp && !any_wr) |=> (cnt == '0)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (step && !stop && !any_wr && !(clr_en && cnt > cmp))
      |=> (cnt == $past(cnt) + CNT_W'(1))); // R6

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0)); // R8

  AST_WRITE_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (cnt[HALF-1:0] == $past(bus_wdata[HALF-1:0]) &&
                           cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF]))); // R9
endmodule

bind tick_timer64 tick_timer64_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .cmp(cmp),
  .stop(ctrl.stop), .clr_en(ctrl.clr_en), .step(step), .wr_lo(wr_cnt_lo),
  .wr_hi(wr_cnt_hi), .timer_irq(timer_irq)
);

// File: tb/tick_timer64_tb.sv
`timescale 1ns/1ps
module tick_timer64_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        aon_tick = 1'b0;
  logic        toggle_in = 1'b0;
  logic        timer_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_timer64 u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aon_tick(aon_tick),
    .toggle_in(toggle_in), .timer_irq(timer_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    aon_tick = 1'b1;
    repeat (n) @(negedge clk);
    aon_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, timer_irq}, 32'd0);
    rd(12'h000, d); check("R1 cnt_lo", d, 32'd0);
    rd(12'h004, d); check("R1 cnt_hi", d, 32'd0);
    rd(12'h008, d); check("R1 cmp_lo", d, 32'hFFFFFFFF);
    rd(12'h00C, d); check("R1 cmp_hi", d, 32'hFFFFFFFF);
    rd(12'hFF8, d); check("R1 ctrl", d, 32'd0);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) toggle_in = 1'b1;
      repeat (3 + i) @(negedge clk);
      toggle_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    rd(12'h000, d); check("R10 R7 toggle edges", d, 32'd3);
    @(negedge clk) toggle_in = 1'b1;
    repeat (12) @(negedge clk);
    rd(12'h000, d); check("R7 held high counts once", d, 32'd4);
    toggle_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    wr(12'hFF8, 32'd4);
    wr(12'h00C, 32'd0);
    wr(12'h008, 32'd5);
    wr(12'h000, 32'd5);
    @(negedge clk);
    check("R3 equal gives no irq", {31'd0, timer_irq}, 32'd0);
    tick(1);
    @(negedge clk);
    check("R3 above raises irq", {31'd0, timer_irq}, 32'd1);
    wr(12'h008, 32'd10);
    @(negedge clk);
    check("R3 cmp rewrite drops irq", {31'd0, timer_irq}, 32'd0);
    wr(12'h000, 32'd20);
    repeat (4) @(negedge clk);
    check("R5 level held without clear", {31'd0, timer_irq}, 32'd1);
    rd(12'h000, d); check("R5 counter kept", d, 32'd20);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(12'h008, 32'd3);
    wr(12'h000, 32'd3);
    wr(12'hFF8, 32'd6);
    tick(1);
    @(negedge clk);
    check("R5 pulse high", {31'd0, timer_irq}, 32'd1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, timer_irq}, 32'd0);
    rd(12'h000, d); check("R5 counter cleared", d, 32'd0);
    wr(12'hFF8, 32'd4);
    wr(12'h008, 32'd10);
  endtask

  task automatic t_stop_aon();
    logic [31:0] d;
    wr(12'h000, 32'd20);
    wr(12'hFF8, 32'd5);
    tick(5);
    rd(12'h000, d); check("R4 stop holds", d, 32'd20);
    wr(12'hFF8, 32'd4);
    tick(3);
    rd(12'h000, d); check("R6 aon ticks", d, 32'd23);
  endtask

  task automatic t_write_prio();
    logic [31:0] d;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h100; aon_tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; aon_tick = 1'b0;
    rd(12'h000, d); check("R9 write beats step", d, 32'h100);
    wr(12'h004, 32'd1);
    wr(12'h000, 32'hFFFFFFFF);
    tick(1);
    rd(12'h004, d); check("R9 carry hi", d, 32'd2);
    rd(12'h000, d); check("R9 carry lo", d, 32'd0);
    wr(12'h004, 32'hABCD);
    rd(12'h000, d); check("R9 hi write keeps lo", d, 32'd0);
    rd(12'h004, d); check("R2 hi readback", d, 32'hABCD);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h100, d); check("R8 unmapped read", d, 32'd0);
    wr(12'h010, 32'h5A5A5A5A);
    rd(12'h010, d); check("R8 unmapped write ignored", d, 32'd0);
    wr(12'h009, 32'd0);
    rd(12'h008, d); check("R8 misaligned write ignored", d, 32'd10);
    rd(12'h00A, d); check("R8 misaligned read", d, 32'd0);
    wr(12'hFF8, 32'hFFFFFFF8);
    rd(12'hFF8, d); check("R8 ctrl upper bits", d, 32'd0);
    wr(12'hFF8, 32'hFFFFFFFF);
    rd(12'hFF8, d); check("R8 ctrl low bits", d, 32'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_toggle();
    t_compare();
    t_clear();
    t_stop_aon();
    t_write_prio();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule